// File: doc/BRIEF.md
# External Memory Strobe Pulse Timer

This block times the active-low chip-select, read-strobe and write-strobe pulses for one chip select of an asynchronous static-memory bus. A 32-bit configuration word holds four packed 7-bit length fields. Each field is decoded into a cycle count, and one down-counter per active strobe times that count. A start request carries a read/write flag, a page-mode flag and a flag that marks the last access of a page. The strobes go low together, each is released after its own length, and a one-cycle done pulse follows the release of the longest strobe.

In page-mode reads the block keeps track of whether a page is open. The first access of a page is timed by the read chip-select field. Each later access in the same page is timed by the read-strobe field. The access that carries the page-end flag closes the page.

Top module: `strobe_pulse_timer`

## Requirements
- R1: After reset, ncs_no, nrd_no and nwe_no are high and done_o is low. The configuration word resets to 0x01010101, so every pulse lasts one cycle.
- R2: A 7-bit field f decodes to 256*f[6] + f[5:0] cycles. A field that decodes to zero gives one cycle.
- R3: A standard read (rd_nwr_i=1, page_i=0) drives ncs_no low for the length in bits 30:24 and nrd_no low for the length in bits 22:16, while nwe_no stays high.
- R4: A write (rd_nwr_i=0) drives ncs_no low for the length in bits 14:8 and nwe_no low for the length in bits 6:0, while nrd_no stays high. nrd_no and nwe_no are never low together.
- R5: Every strobe of an access goes low in the first cycle after the clock edge that samples start_i high while idle.
- R6: done_o is high for exactly one cycle: the first cycle in which all strobes are high again after the longest strobe. The block is idle in that cycle and can accept a new start.
- R7: A start request that arrives while an access is in progress is ignored and causes no extra access.
- R8: A configuration write (cfg_we_i) is taken only when the block is idle. A write during an access is dropped. A write taken while idle applies from the next access.
- R9: The first page-mode read of a page drives ncs_no and nrd_no low together for the length in bits 30:24.
- R10: Each later page-mode read of an open page drives ncs_no and nrd_no low for the length in bits 22:16. An access started with page_last_i=1 closes the page, so the next page-mode read is timed as a first access again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable, taken only when idle |
| cfg_wdata_i | input | 32 | Packed pulse-length word |
| start_i | input | 1 | Access start request |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| page_i | input | 1 | Page-mode read |
| page_last_i | input | 1 | This access is the last of the page |
| ncs_no | output | 1 | Chip select, active low |
| nrd_no | output | 1 | Read strobe, active low |
| nwe_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-cycle access completion pulse |

## Verification
All strobes of an access are due low in cycle 1, counting from the edge that samples start_i. A strobe of length L is low in cycles 1 through L, and done_o is due in cycle max(L)+1. The bench drives inputs and samples outputs on falling edges and numbers every cycle from the accepting edge. For each strobe it records the first low cycle, the number of low cycles and the done cycle, and compares them with lengths it decodes arithmetically from the word it wrote. A configuration write takes effect at the following rising edge, so each access starts only after that edge.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int unsigned FIELD_W = 7;
  localparam int unsigned CNT_W   = 9;  // up to 256 + 63

  typedef struct packed {
    logic [FIELD_W-1:0] rd_cs;
    logic [FIELD_W-1:0] rd_st;
    logic [FIELD_W-1:0] wr_cs;
    logic [FIELD_W-1:0] wr_st;
  } spt_fields_t;

  function automatic logic [CNT_W-1:0] spt_len(input logic [FIELD_W-1:0] f);
    logic [CNT_W-1:0] l;
    l = {f[FIELD_W-1], 2'b00, f[FIELD_W-2:0]};
    return (l == '0) ? CNT_W'(1) : l;
  endfunction
endpackage

// File: rtl/spt_cfg_reg.sv
module spt_cfg_reg
  import spt_pkg::*;
#(
  parameter logic [31:0] RESET_VAL = 32'h0101_0101
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        busy_i,
  input  logic [31:0] wdata_i,
  output spt_fields_t fields_o
);
  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cfg_q <= RESET_VAL;
    else if (we_i && !busy_i)  cfg_q <= wdata_i;
  end

  assign fields_o.rd_cs = cfg_q[30:24];
  assign fields_o.rd_st = cfg_q[22:16];
  assign fields_o.wr_cs = cfg_q[14:8];
  assign fields_o.wr_st = cfg_q[6:0];

  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> $stable(cfg_q));
endmodule

// File: rtl/spt_pulse_cnt.sv
module spt_pulse_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             on_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign on_o  = (cnt_q != '0);
  assign end_o = (cnt_q <= CNT_W'(1));

  p_load_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> on_o);
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_o && !load_i) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/spt_seq.sv
module spt_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_nwr_i,
  input  logic page_i,
  input  logic page_last_i,
  input  logic cs_end_i,
  input  logic st_end_i,
  output logic load_o,
  output logic busy_o,
  output logic is_rd_o,
  output logic page_open_o,
  output logic done_o
);
  logic act_q, rd_q, pg_q, last_q, open_q, done_q, fin;

  assign load_o = start_i && !act_q;
  assign fin    = act_q && cs_end_i && st_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      pg_q   <= 1'b0;
      last_q <= 1'b0;
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (load_o) begin
        act_q  <= 1'b1;
        rd_q   <= rd_nwr_i;
        pg_q   <= page_i && rd_nwr_i;
        last_q <= page_last_i;
      end else if (fin) begin
        act_q <= 1'b0;
        if (pg_q) open_q <= !last_q;
      end
    end
  end

  assign busy_o      = act_q;
  assign is_rd_o     = load_o ? rd_nwr_i : rd_q;
  assign page_open_o = open_q;
  assign done_o      = done_q;

  p_ignore_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && start_i) |=> ($stable(rd_q) && $stable(pg_q)));
  p_done_after_fin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> (done_o && !act_q));
endmodule

// File: rtl/strobe_pulse_timer.sv
module strobe_pulse_timer
  import spt_pkg::*;
#(
  parameter logic [31:0] CFG_RESET = 32'h0101_0101
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        start_i,
  input  logic        rd_nwr_i,
  input  logic        page_i,
  input  logic        page_last_i,
  output logic        ncs_no,
  output logic        nrd_no,
  output logic        nwe_no,
  output logic        done_o
);
  localparam int unsigned N_CNT = 2;  // 0: chip select, 1: data strobe

  spt_fields_t      fields;
  logic             load, busy, is_rd, page_open;
  logic [CNT_W-1:0] len   [N_CNT];
  logic [N_CNT-1:0] on, fin;
  logic [CNT_W-1:0] page_len;

  spt_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .busy_i(busy),
    .wdata_i(cfg_wdata_i), .fields_o(fields)
  );

  spt_seq u_seq (
    .clk_i, .rst_ni, .start_i, .rd_nwr_i, .page_i, .page_last_i,
    .cs_end_i(fin[0]), .st_end_i(fin[1]), .load_o(load), .busy_o(busy),
    .is_rd_o(is_rd), .page_open_o(page_open), .done_o
  );

  // page mode: both strobes share one duration
  assign page_len = page_open ? spt_len(fields.rd_st) : spt_len(fields.rd_cs);

  always_comb begin
    if (rd_nwr_i && page_i) begin
      len[0] = page_len;
      len[1] = page_len;
    end else if (rd_nwr_i) begin
      len[0] = spt_len(fields.rd_cs);
      len[1] = spt_len(fields.rd_st);
    end else begin
      len[0] = spt_len(fields.wr_cs);
      len[1] = spt_len(fields.wr_st);
    end
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    spt_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .load_i(load), .len_i(len[g]),
      .on_o(on[g]), .end_o(fin[g])
    );
  end

  assign ncs_no = !on[0];
  assign nrd_no = !(on[1] && is_rd);
  assign nwe_no = !(on[1] && !is_rd);

  p_strobes_together_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ncs_no) |-> (!nrd_no || !nwe_no));
  p_rd_wr_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nrd_no && !nwe_no));
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ncs_no && nrd_no && nwe_no));
endmodule

// File: tb/strobe_pulse_timer_tb.sv
`timescale 1ns/1ps
module strobe_pulse_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0, rd_nwr = 1'b0, page = 1'b0, page_last = 1'b0;
  logic        ncs_n, nrd_n, nwe_n, done;

  int n_chk = 0, n_bad = 0;
  int cs_cnt, rd_cnt, we_cnt, cs_first, rd_first, we_first, done_at, done_cnt;
  logic [31:0] inj_data;

  always #2.5 clk = ~clk;

  strobe_pulse_timer u_dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .start_i(start), .rd_nwr_i(rd_nwr), .page_i(page), .page_last_i(page_last),
    .ncs_no(ncs_n), .nrd_no(nrd_n), .nwe_no(nwe_n), .done_o(done)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dec(logic [6:0] f);
    int l = (f[6] ? 256 : 0) + int'(f[5:0]);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic logic [6:0] val_of(int i);
    case (i % 8)
      0: return 7'd0;   1: return 7'd1;   2: return 7'd2;   3: return 7'd5;
      4: return 7'd63;  5: return 7'd64;  6: return 7'd65;  default: return 7'd127;
    endcase
  endfunction

  task automatic write_cfg(logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // inject > 0: at that cycle, raise start (write) and cfg_we with inj_data
  task automatic run(logic rd, logic pg, logic last, int inject);
    @(negedge clk);
    start = 1'b1; rd_nwr = rd; page = pg; page_last = last;
    @(negedge clk);
    start = 1'b0;
    cs_cnt = 0; rd_cnt = 0; we_cnt = 0; done_cnt = 0;
    cs_first = -1; rd_first = -1; we_first = -1; done_at = -1;
    for (int k = 1; k <= 700 && done_at < 0; k++) begin
      if (!ncs_n) begin cs_cnt++; if (cs_first < 0) cs_first = k; end
      if (!nrd_n) begin rd_cnt++; if (rd_first < 0) rd_first = k; end
      if (!nwe_n) begin we_cnt++; if (we_first < 0) we_first = k; end
      if (done)   begin done_cnt++; done_at = k; end
      start  = (k == inject);
      rd_nwr = (k == inject) ? 1'b0 : rd;
      cfg_we = (k == inject);
      cfg_wdata = inj_data;
      @(negedge clk);
    end
    start = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic check_acc(string req, logic rd, int cs_exp, int st_exp);
    int mx = (cs_exp > st_exp) ? cs_exp : st_exp;
    chk(req, "ncs low cycles", cs_cnt, cs_exp);
    chk("R5", "ncs first low cycle", cs_first, 1);
    chk(req, "data strobe low cycles", rd ? rd_cnt : we_cnt, st_exp);
    chk("R5", "data strobe first low cycle", rd ? rd_first : we_first, 1);
    chk("R4", "other strobe low cycles", rd ? we_cnt : rd_cnt, 0);
    chk("R6", "done cycle", done_at, mx + 1);
    chk("R6", "done pulse count", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ncs_no", ncs_n, 1);
    chk("R1", "nrd_no", nrd_n, 1);
    chk("R1", "nwe_no", nwe_n, 1);
    chk("R1", "done_o", done, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run(1'b1, 1'b0, 1'b0, 0); check_acc("R1", 1'b1, 1, 1);
    run(1'b0, 1'b0, 1'b0, 0); check_acc("R1", 1'b0, 1, 1);

    // R2/R3/R4 sweep over encodings, incl. zero and bit-6 values
    for (int i = 0; i < 8; i++) begin
      logic [6:0] a, b, c, d;
      a = val_of(i); b = val_of(i + 3); c = val_of(i + 5); d = val_of(i + 1);
      write_cfg({1'b0, a, 1'b0, b, 1'b0, c, 1'b0, d});
      run(1'b1, 1'b0, 1'b0, 0); check_acc("R3", 1'b1, dec(a), dec(b));
      run(1'b0, 1'b0, 1'b0, 0); check_acc("R4", 1'b0, dec(c), dec(d));
    end
    // R2 explicit: zero field and 0x40 field
    write_cfg({8'h00, 8'h40, 8'h41, 8'h00});
    run(1'b1, 1'b0, 1'b0, 0); check_acc("R2", 1'b1, 1, 256);
    run(1'b0, 1'b0, 1'b0, 0); check_acc("R2", 1'b0, 257, 1);

    // R7/R8: start and cfg write during a read are ignored
    write_cfg({8'd9, 8'd6, 8'd3, 8'd4});
    inj_data = {8'd2, 8'd2, 8'd2, 8'd2};
    run(1'b1, 1'b0, 1'b0, 3); check_acc("R7", 1'b1, 9, 6);
    for (int k = 0; k < 4; k++) begin
      chk("R7", "ncs high after ignored start", ncs_n, 1);
      chk("R7", "nwe high after ignored start", nwe_n, 1);
      @(negedge clk);
    end
    run(1'b1, 1'b0, 1'b0, 0); check_acc("R8", 1'b1, 9, 6);
    write_cfg({8'd2, 8'd7, 8'd3, 8'd4});
    run(1'b1, 1'b0, 1'b0, 0); check_acc("R8", 1'b1, 2, 7);

    // R9/R10 page mode
    write_cfg({8'd5, 8'd2, 8'd3, 8'd4});
    run(1'b1, 1'b1, 1'b0, 0); check_acc("R9", 1'b1, 5, 5);
    run(1'b1, 1'b1, 1'b0, 0); check_acc("R10", 1'b1, 2, 2);
    run(1'b1, 1'b1, 1'b1, 0); check_acc("R10", 1'b1, 2, 2);
    run(1'b1, 1'b1, 1'b1, 0); check_acc("R9", 1'b1, 5, 5);
    write_cfg({8'h41, 8'd3, 8'd3, 8'd4});
    run(1'b1, 1'b1, 1'b0, 0); check_acc("R9", 1'b1, 257, 257);
    run(1'b1, 1'b1, 1'b1, 0); check_acc("R10", 1'b1, 3, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule